// File: doc/BRIEF.md
# DMA Programming Register Slave

This block is the register front end of a memory-to-memory DMA engine. It sits behind the address decoder as an AXI slave. Every access is a single beat, and it carries a local byte offset from which the register-space base has already been removed. Software first loads a source address, a destination address and a transfer length into three word registers. These registers drive the engine continuously. Software then writes the control word with bit 0 set. The block does not store that write. It emits a start strobe that lasts exactly one clock cycle.

The status word is assembled when a read is accepted. The engine's busy and error levels are sampled live at that moment. The done indication is held in a sticky flag. A one-cycle done strobe from the engine sets the flag, and the next start command clears it. The write address and write data may reach the slave in either order. The write takes effect only once both have been captured, and only then is a response offered.

Top module: `dmacfg_regs`

## Requirements
- R1: After a synchronous reset: the source, destination and length outputs are zero, the start strobe is low, and neither BVALID nor RVALID is asserted.
- R2: A write to offset 0x08 sets the source address, 0x0C sets the destination address and 0x10 sets the length. Each new value appears on the matching output, and a read of the same offset returns it.
- R3: AW and W are accepted in either order or in the same cycle. BVALID stays low until both have been accepted. BVALID then rises one cycle after the later of the two handshakes, carries BRESP = 2'b00 (OKAY), and stays high until BREADY.
- R4: A write to offset 0x00 with data bit 0 = 1 raises the start strobe for exactly one cycle. That cycle is the first cycle of BVALID for the write. A write to offset 0x00 with bit 0 = 0 raises no strobe.
- R5: A read of offset 0x00 always returns zero.
- R6: A read of offset 0x04 returns a status word: bit 0 is the done flag, bit 1 is the engine busy level, bit 2 is the engine error level, and all other bits are zero. Busy and error are taken at the cycle in which the read address is accepted.
- R7: A one-cycle done pulse from the engine sets the done flag. The flag stays set until a start command clears it, on the same edge that raises the start strobe.
- R8: Offset 0x04 is read-only. A write to it gets an OKAY response, changes no register and raises no strobe.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 returns zero with RRESP = 2'b00. A write to any such offset changes no register.
- R10: Only one read is outstanding at a time. ARREADY is low while RVALID is high, and RDATA holds steady until RREADY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte offset |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte offset |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| dma_src | output | DATA_W | Programmed source address |
| dma_dst | output | DATA_W | Programmed destination address |
| dma_len | output | DATA_W | Programmed transfer length |
| dma_start | output | 1 | One-cycle start strobe |
| eng_done | input | 1 | Engine completion pulse |
| eng_busy | input | 1 | Engine busy level |
| eng_error | input | 1 | Engine error level |

## Verification
The hardest case to reach from the ports is a write whose two halves are split apart. One channel has to sit captured for several cycles while the other is still absent. Each directed write task therefore has an ordering argument. With that argument it drives only AW or only W, releases that channel after its handshake, and checks for three cycles that no response appears. Only then does it present the other half. A second case that is hard to reach is a done flag still held after the engine has gone idle. To get there, the bench pulses done for a single cycle, drops busy and error, and reads status twice before it issues a start that should clear the flag.

// File: rtl/dmacfg_pkg.sv
`timescale 1ns/1ps
package dmacfg_pkg;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // byte offsets in the local register window
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_SRC  = 'h08;
  localparam int OFS_DST  = 'h0C;
  localparam int OFS_LEN  = 'h10;

  // number of plain word registers starting at OFS_SRC, one word apart
  localparam int CFG_WORDS = 3;

  // status word bit positions
  localparam int ST_DONE = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_ERR  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_CFG
  } reg_sel_e;

  function automatic reg_sel_e sel_of(input logic [31:0] ofs);
    if (ofs == 32'(OFS_CTRL))      return SEL_CTRL;
    else if (ofs == 32'(OFS_STAT)) return SEL_STAT;
    else if (ofs >= 32'(OFS_SRC) && ofs < 32'(OFS_SRC + 4 * CFG_WORDS) && ofs[1:0] == 2'b00)
      return SEL_CFG;
    else return SEL_NONE;
  endfunction

endpackage

// File: rtl/dmacfg_wr_join.sv
`timescale 1ns/1ps
module dmacfg_wr_join #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  import dmacfg_pkg::*;

  logic              aw_held, w_held, bvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign awready     = !aw_held && !bvalid_q;
  assign wready      = !w_held && !bvalid_q;
  assign commit      = aw_held && w_held;
  assign commit_addr = addr_q;
  assign commit_data = data_q;
  assign bvalid      = bvalid_q;
  assign bresp       = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      bvalid_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        addr_q  <= awaddr;
      end
      if (wvalid && wready) begin
        w_held <= 1'b1;
        data_q <= wdata;
      end
      if (commit) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  // R3
  bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  // R3
  bvalid_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bvalid) |-> $past(aw_held && w_held));
  // R3
  no_accept_in_resp_chk: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> !awready && !wready);

endmodule

// File: rtl/dmacfg_bank.sv
`timescale 1ns/1ps
module dmacfg_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [DATA_W-1:0] commit_data,
  input  logic              eng_done,
  input  logic              eng_busy,
  input  logic              eng_error,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dma_src,
  output logic [DATA_W-1:0] dma_dst,
  output logic [DATA_W-1:0] dma_len,
  output logic              dma_start
);
  import dmacfg_pkg::*;

  logic [DATA_W-1:0] cfg_q [CFG_WORDS];
  logic              start_q, done_q, start_set;
  logic [DATA_W-1:0] status_word;

  assign start_set = commit && (sel_of(32'(commit_addr)) == SEL_CTRL) && commit_data[0];

  for (genvar i = 0; i < CFG_WORDS; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(OFS_SRC + 4 * i);
    always_ff @(posedge clk) begin
      if (rst) cfg_q[i] <= '0;
      else if (commit && commit_addr == MY_OFS) cfg_q[i] <= commit_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start_set;
      if (start_set)     done_q <= 1'b0;
      else if (eng_done) done_q <= 1'b1;
    end
  end

  always_comb begin
    status_word          = '0;
    status_word[ST_DONE] = done_q;
    status_word[ST_BUSY] = eng_busy;
    status_word[ST_ERR]  = eng_error;
  end

  always_comb begin
    case (sel_of(32'(rd_addr)))
      SEL_STAT: rd_word = status_word;
      SEL_CFG:  rd_word = cfg_q[(32'(rd_addr) - 32'(OFS_SRC)) >> 2];
      default:  rd_word = '0;
    endcase
  end

  assign dma_src   = cfg_q[0];
  assign dma_dst   = cfg_q[1];
  assign dma_len   = cfg_q[2];
  assign dma_start = start_q;

  // R4
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    dma_start |=> !dma_start);
  // R7
  done_cleared_by_start_chk: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> !done_q);
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_q && !start_set |=> done_q);

endmodule

// File: rtl/dmacfg_rd_port.sv
`timescale 1ns/1ps
module dmacfg_rd_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic [ADDR_W-1:0] lookup_addr,
  input  logic [DATA_W-1:0] lookup_word
);
  import dmacfg_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready     = !rvalid_q;
  assign lookup_addr = araddr;
  assign rvalid      = rvalid_q;
  assign rdata       = rdata_q;
  assign rresp       = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= lookup_word;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R10
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !arready);

endmodule

// File: rtl/dmacfg_regs.sv
`timescale 1ns/1ps
module dmacfg_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic [DATA_W-1:0] dma_src,
  output logic [DATA_W-1:0] dma_dst,
  output logic [DATA_W-1:0] dma_len,
  output logic              dma_start,
  input  logic              eng_done,
  input  logic              eng_busy,
  input  logic              eng_error
);

  logic              commit;
  logic [ADDR_W-1:0] commit_addr, lookup_addr;
  logic [DATA_W-1:0] commit_data, lookup_word;

  dmacfg_wr_join #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  dmacfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
    .eng_done(eng_done), .eng_busy(eng_busy), .eng_error(eng_error),
    .rd_addr(lookup_addr), .rd_word(lookup_word),
    .dma_src(dma_src), .dma_dst(dma_dst), .dma_len(dma_len),
    .dma_start(dma_start)
  );

  dmacfg_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .lookup_addr(lookup_addr), .lookup_word(lookup_word)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !s_bvalid && !s_rvalid && !dma_start);

endmodule

// File: tb/dmacfg_regs_bench.sv
`timescale 1ns/1ps
module dmacfg_regs_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [7:0]  s_awaddr = '0, s_araddr = '0;
  logic [31:0] s_wdata = '0;
  logic        eng_done = 0, eng_busy = 0, eng_error = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid, dma_start;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata, dma_src, dma_dst, dma_len;

  int checks = 0, errors = 0, starts_seen = 0;

  always #2 clk = ~clk;

  dmacfg_regs u_dmacfg_regs (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .dma_src(dma_src), .dma_dst(dma_dst), .dma_len(dma_len), .dma_start(dma_start),
    .eng_done(eng_done), .eng_busy(eng_busy), .eng_error(eng_error)
  );

  always @(posedge clk) if (!rst && dma_start) starts_seen++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_hs();
    while (s_awvalid || s_wvalid) begin
      bit a_hs = s_awvalid && s_awready;
      bit w_hs = s_wvalid && s_wready;
      @(negedge clk);
      if (a_hs) s_awvalid = 0;
      if (w_hs) s_wvalid = 0;
    end
  endtask

  // order: 0 both together, 1 address first, 2 data first
  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input int order, input bit exp_pulse);
    int base = starts_seen;
    int t = 0;
    @(negedge clk);
    if (order != 2) begin s_awvalid = 1; s_awaddr = a; end
    if (order != 1) begin s_wvalid = 1; s_wdata = d; end
    run_hs();
    if (order != 0) begin
      for (int k = 0; k < 3; k++) begin
        chk(!s_bvalid, "R3 response before both halves", 32'(s_bvalid), 0);
        @(negedge clk);
      end
      if (order == 1) begin s_wvalid = 1; s_wdata = d; end
      else begin s_awvalid = 1; s_awaddr = a; end
      run_hs();
    end
    while (!s_bvalid && t < 20) begin @(negedge clk); t++; end
    chk(t == 1, "R3 bvalid one cycle after last handshake", 32'(t), 1);
    chk(s_bresp == 2'b00, "R3 bresp okay", 32'(s_bresp), 0);
    chk(dma_start == exp_pulse, "R4 strobe with first bvalid cycle", 32'(dma_start), 32'(exp_pulse));
    @(negedge clk);
    chk(s_bvalid, "R3 bvalid held without bready", 32'(s_bvalid), 1);
    chk(!dma_start, "R4 strobe single cycle", 32'(dma_start), 0);
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;
    chk(!s_bvalid, "R3 bvalid drops after bready", 32'(s_bvalid), 0);
    chk(starts_seen - base == int'(exp_pulse), "R4 strobe count", 32'(starts_seen - base), 32'(exp_pulse));
  endtask

  task automatic axi_rd(input logic [7:0] a, input bit stall, output logic [31:0] d);
    @(negedge clk);
    s_arvalid = 1; s_araddr = a;
    while (s_arvalid) begin
      bit hs = s_arvalid && s_arready;
      @(negedge clk);
      if (hs) s_arvalid = 0;
    end
    d = s_rdata;
    if (stall) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(s_rvalid && s_rdata == d && !s_arready, "R10 rdata held, no new read", s_rdata, d);
      end
    end
    chk(s_rresp == 2'b00, "R9 rresp okay", 32'(s_rresp), 0);
    s_rready = 1;
    @(negedge clk);
    s_rready = 0;
  endtask

  task automatic t_reset();
    chk(dma_src == 0 && dma_dst == 0 && dma_len == 0, "R1 config zero", dma_src | dma_dst | dma_len, 0);
    chk(!s_bvalid && !s_rvalid && !dma_start, "R1 outputs quiet",
        {29'd0, s_bvalid, s_rvalid, dma_start}, 0);
  endtask

  task automatic t_config();
    logic [31:0] r;
    axi_wr(8'h08, 32'h0000_0040, 0, 0);
    axi_wr(8'h0C, 32'h0000_0180, 1, 0);
    axi_wr(8'h10, 32'd16, 2, 0);
    chk(dma_src == 32'h40, "R2 source output", dma_src, 32'h40);
    chk(dma_dst == 32'h180, "R2 destination output", dma_dst, 32'h180);
    chk(dma_len == 32'd16, "R2 length output", dma_len, 16);
    axi_rd(8'h08, 1, r); chk(r == 32'h40, "R2 source readback", r, 32'h40);
    axi_rd(8'h0C, 0, r); chk(r == 32'h180, "R2 destination readback", r, 32'h180);
    axi_rd(8'h10, 0, r); chk(r == 32'd16, "R2 length readback", r, 16);
  endtask

  task automatic t_start();
    logic [31:0] r;
    axi_wr(8'h00, 32'h0000_0001, 0, 1);
    axi_wr(8'h00, 32'hFFFF_FFFE, 2, 0);
    axi_wr(8'h00, 32'h0000_0003, 1, 1);
    axi_rd(8'h00, 0, r); chk(r == 0, "R5 control reads zero", r, 0);
  endtask

  task automatic t_status();
    logic [31:0] r;
    eng_busy = 1;
    axi_rd(8'h04, 0, r); chk(r == 32'h2, "R6 busy bit", r, 32'h2);
    eng_busy = 0; eng_error = 1;
    axi_rd(8'h04, 0, r); chk(r == 32'h4, "R6 error bit", r, 32'h4);
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    axi_rd(8'h04, 0, r); chk(r == 32'h5, "R7 done set", r, 32'h5);
    eng_error = 0;
    repeat (3) @(negedge clk);
    axi_rd(8'h04, 1, r); chk(r == 32'h1, "R7 done sticky", r, 32'h1);
    axi_rd(8'h04, 0, r); chk(r == 32'h1, "R7 done sticky on reread", r, 32'h1);
    axi_wr(8'h04, 32'hFFFF_FFFF, 0, 0);
    axi_rd(8'h04, 0, r); chk(r == 32'h1, "R8 status write ignored", r, 32'h1);
    chk(dma_src == 32'h40 && dma_dst == 32'h180 && dma_len == 16, "R8 config untouched", dma_src, 32'h40);
    axi_wr(8'h00, 32'h1, 0, 1);
    axi_rd(8'h04, 0, r); chk(r == 32'h0, "R7 start clears done", r, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    axi_rd(8'h14, 0, r); chk(r == 0, "R9 read 0x14 zero", r, 0);
    axi_rd(8'h80, 0, r); chk(r == 0, "R9 read 0x80 zero", r, 0);
    axi_rd(8'h0A, 0, r); chk(r == 0, "R9 read misaligned zero", r, 0);
    axi_wr(8'h14, 32'hDEAD_BEEF, 0, 0);
    axi_wr(8'h09, 32'h1234_5678, 1, 0);
    axi_wr(8'hFC, 32'h0000_0001, 2, 0);
    chk(dma_src == 32'h40, "R9 source unchanged", dma_src, 32'h40);
    chk(dma_dst == 32'h180, "R9 destination unchanged", dma_dst, 32'h180);
    chk(dma_len == 32'd16, "R9 length unchanged", dma_len, 16);
    axi_rd(8'h08, 0, r); chk(r == 32'h40, "R9 source readback unchanged", r, 32'h40);
  endtask

  bit finished = 0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_config();
    t_start();
    t_status();
    t_unmapped();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule